// File: doc/BRIEF.md
# Multichannel Threshold Receive Buffer

This block holds received data words for many channels between a protocol handler and a bus transfer engine. The handler writes one word at a time. Each word carries a channel number and a flag that marks the last word of a frame. The storage is one shared memory that holds a small fixed slot for every channel. A global occupancy limit caps the total number of words that may be held at once.

Each channel has a 2-bit threshold code that sets how many words must build up before the channel asks for a transfer. A channel also asks for a transfer as soon as a frame-end word is stored for it, whatever its threshold. A round-robin arbiter picks one requesting channel at a time. The block offers that channel with a burst length. Once the transfer engine accepts the offer, the burst's words stream out in write order, and the last word of the burst is marked.

When a word cannot be stored, the block drops it and sets a sticky overflow flag for that channel. This happens when the global limit is reached or when the channel's slot is full.

Top module: `rx_thresh_buf`

## Requirements
- R1: After reset, wr_ready_o is 1, req_valid_o and rd_valid_o are 0, and every overflow flag is 0. Every channel's threshold code is 0, so a single stored word raises a request of length 1.
- R2: The threshold code on cfg_thr_i is written for channel cfg_ch_i when cfg_we_i is high. Code 0 means 1 word, code 1 means 2, code 2 means 4 and code 3 means 8. A channel with no frame-end word stored requests a transfer only once its pending count is at least its threshold.
- R3: Storing a word with the frame-end flag set makes its channel request a transfer even when the pending count is below the threshold. When that word is read, rd_eof_o and rd_last_o are both 1.
- R4: req_len_o is the smallest of three values: the pending count, the threshold, and the number of words up to and including the oldest stored frame-end word.
- R5: The words of a burst come out in the order they were written for that channel, each with its own data and frame-end flag. rd_last_o is 1 on exactly the final word of the burst.
- R6: Channels are served round-robin. After channel c is served, the next offer goes to the first requesting channel above c, wrapping from the highest index back to 0.
- R7: Only one burst runs at a time. A burst starts on a cycle where req_valid_o and req_ready_i are both 1. While the burst runs, req_valid_o is 0 and rd_valid_o is 1. Each cycle with rd_ready_i high consumes one word.
- R8: Once BUF_WORDS words are held, wr_ready_o is 0. A word offered while wr_ready_o is 0 is dropped, and the overflow flag of its channel is set. wr_ready_o returns to 1 when words are read out.
- R9: A word written to a channel whose slot already holds SLOT_WORDS words is dropped, and that channel's flag is set. Other channels are not affected. Overflow flags are bit-per-channel and stay set until reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| cfg_we_i | input | 1 | Threshold write strobe |
| cfg_ch_i | input | $clog2(N_CH) | Channel whose threshold is written |
| cfg_thr_i | input | 2 | Threshold code (0:1, 1:2, 2:4, 3:8 words) |
| wr_valid_i | input | 1 | Write word valid |
| wr_ch_i | input | $clog2(N_CH) | Channel of the written word |
| wr_data_i | input | DW | Written data word |
| wr_eof_i | input | 1 | Written word ends a frame |
| wr_ready_o | output | 1 | Global space available |
| req_valid_o | output | 1 | Transfer offer valid |
| req_ch_o | output | $clog2(N_CH) | Offered channel |
| req_len_o | output | $clog2(SLOT_WORDS+1) | Offered burst length in words |
| req_ready_i | input | 1 | Transfer engine accepts the offer |
| rd_valid_o | output | 1 | Burst word valid |
| rd_data_o | output | DW | Burst word data |
| rd_eof_o | output | 1 | Burst word ends a frame |
| rd_last_o | output | 1 | Final word of the burst |
| rd_ready_i | input | 1 | Transfer engine takes the current word |
| ovf_o | output | N_CH | Sticky per-channel overflow flags |

## Verification
The assertions assume that the writer and the transfer engine drive known values from reset onward. They also assume that rd_ready_i is meaningful only while a burst runs, and that a threshold change does not race with the acceptance of the same channel's offer. The stimulus changes every input on the falling clock edge. It reconfigures thresholds only while no offer is being accepted, and it offers words past the global limit only on purpose, to exercise the drop path. Burst acceptance and word consumption are always driven as clean single-cycle or back-to-back handshakes, so the one-burst and frame-end properties see only legal sequences.

// File: rtl/rxb_pkg.sv
package rxb_pkg;
  typedef enum logic {ST_IDLE, ST_BURST} burst_st_e;

  // 2-bit code -> threshold in words (1, 2, 4, 8)
  function automatic logic [3:0] thr_words(input logic [1:0] code);
    return 4'd1 << code;
  endfunction
endpackage

// File: rtl/rxb_store.sv
module rxb_store #(
  parameter int N_CH = 256,
  parameter int SLOT = 8,
  parameter int DW   = 32,
  localparam int CH_W  = $clog2(N_CH),
  localparam int PTR_W = $clog2(SLOT),
  localparam int CNT_W = $clog2(SLOT + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             push_i,
  input  logic [CH_W-1:0]  push_ch_i,
  input  logic [DW-1:0]    push_data_i,
  input  logic             push_eof_i,
  input  logic             pop_i,
  input  logic [CH_W-1:0]  pop_ch_i,
  output logic [DW-1:0]    head_data_o,
  output logic             head_eof_o,
  input  logic [CH_W-1:0]  q_ch_i,
  output logic [CNT_W-1:0] q_eof_off_o,
  output logic [CNT_W-1:0] cnt_o [N_CH],
  output logic [N_CH-1:0]  eof_any_o
);
  logic [DW-1:0]    mem_q  [N_CH*SLOT];
  logic [SLOT-1:0]  eofb_q [N_CH];
  logic [PTR_W-1:0] wptr_q [N_CH];
  logic [PTR_W-1:0] rptr_q [N_CH];
  logic [CNT_W-1:0] cnt_q  [N_CH];
  logic [CNT_W-1:0] eofc_q [N_CH];

  always_ff @(posedge clk_i) begin
    if (push_i) begin
      mem_q[{push_ch_i, wptr_q[push_ch_i]}]  <= push_data_i;
      eofb_q[push_ch_i][wptr_q[push_ch_i]]   <= push_eof_i;
    end
  end

  assign head_data_o = mem_q[{pop_ch_i, rptr_q[pop_ch_i]}];
  assign head_eof_o  = eofb_q[pop_ch_i][rptr_q[pop_ch_i]];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < N_CH; c++) begin
        wptr_q[c] <= '0;
        rptr_q[c] <= '0;
        cnt_q[c]  <= '0;
        eofc_q[c] <= '0;
      end
    end else begin
      if (push_i) wptr_q[push_ch_i] <= wptr_q[push_ch_i] + 1'b1;
      if (pop_i)  rptr_q[pop_ch_i]  <= rptr_q[pop_ch_i] + 1'b1;
      for (int c = 0; c < N_CH; c++) begin
        logic inc, dec, einc, edec;
        inc  = push_i && (push_ch_i == CH_W'(c));
        dec  = pop_i && (pop_ch_i == CH_W'(c));
        einc = inc && push_eof_i;
        edec = dec && head_eof_o;
        cnt_q[c]  <= cnt_q[c] + {{(CNT_W-1){1'b0}}, inc} - {{(CNT_W-1){1'b0}}, dec};
        eofc_q[c] <= eofc_q[c] + {{(CNT_W-1){1'b0}}, einc} - {{(CNT_W-1){1'b0}}, edec};
      end
    end
  end

  assign cnt_o = cnt_q;

  always_comb begin
    for (int c = 0; c < N_CH; c++) eof_any_o[c] = (eofc_q[c] != '0);
  end

  // offset of the oldest frame-end word of q_ch_i, SLOT if none
  always_comb begin
    q_eof_off_o = CNT_W'(SLOT);
    for (int i = SLOT - 1; i >= 0; i--) begin
      if ((CNT_W'(i) < cnt_q[q_ch_i]) &&
          eofb_q[q_ch_i][rptr_q[q_ch_i] + PTR_W'(i)])
        q_eof_off_o = CNT_W'(i);
    end
  end

  AST_NO_PUSH_FULL: assert property (@(posedge clk_i) disable iff (!rst_ni)
    push_i |-> (cnt_q[push_ch_i] < CNT_W'(SLOT))); // R9
  AST_NO_POP_EMPTY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    pop_i |-> (cnt_q[pop_ch_i] != '0)); // R5
endmodule

// File: rtl/rxb_rr_arb.sv
module rxb_rr_arb #(
  parameter int N = 256,
  localparam int CH_W = $clog2(N)
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N-1:0]    req_i,
  input  logic            adv_i,
  output logic            gnt_valid_o,
  output logic [CH_W-1:0] gnt_ch_o
);
  logic [CH_W-1:0] last_q;

  // first requester after last_q; descending loop so smallest offset wins
  always_comb begin
    gnt_valid_o = 1'b0;
    gnt_ch_o    = last_q;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[last_q + CH_W'(i + 1)]) begin
        gnt_valid_o = 1'b1;
        gnt_ch_o    = last_q + CH_W'(i + 1);
      end
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)    last_q <= CH_W'(N - 1);
    else if (adv_i) last_q <= gnt_ch_o;
  end

  AST_ADV_HAS_GNT: assert property (@(posedge clk_i) disable iff (!rst_ni)
    adv_i |-> gnt_valid_o); // R6
endmodule

// File: rtl/rx_thresh_buf.sv
module rx_thresh_buf #(
  parameter int N_CH       = 256,
  parameter int SLOT_WORDS = 8,
  parameter int BUF_WORDS  = 512,
  parameter int DW         = 32,
  localparam int CH_W   = $clog2(N_CH),
  localparam int CNT_W  = $clog2(SLOT_WORDS + 1),
  localparam int GCNT_W = $clog2(BUF_WORDS + 1)
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             cfg_we_i,
  input  logic [CH_W-1:0]  cfg_ch_i,
  input  logic [1:0]       cfg_thr_i,
  input  logic             wr_valid_i,
  input  logic [CH_W-1:0]  wr_ch_i,
  input  logic [DW-1:0]    wr_data_i,
  input  logic             wr_eof_i,
  output logic             wr_ready_o,
  output logic             req_valid_o,
  output logic [CH_W-1:0]  req_ch_o,
  output logic [CNT_W-1:0] req_len_o,
  input  logic             req_ready_i,
  output logic             rd_valid_o,
  output logic [DW-1:0]    rd_data_o,
  output logic             rd_eof_o,
  output logic             rd_last_o,
  input  logic             rd_ready_i,
  output logic [N_CH-1:0]  ovf_o
);
  import rxb_pkg::*;

  logic [1:0]        thr_q [N_CH];
  logic [GCNT_W-1:0] gcnt_q;
  logic [N_CH-1:0]   ovf_q;
  burst_st_e         st_q;
  logic [CH_W-1:0]   bch_q;
  logic [CNT_W-1:0]  left_q;

  logic [CNT_W-1:0]  cnt [N_CH];
  logic [N_CH-1:0]   eof_any, req_vec;
  logic [CNT_W-1:0]  eof_off, thr_g, len_c;
  logic              gnt_valid, push, drop, pop, accept;
  logic [CH_W-1:0]   gnt_ch;

  assign wr_ready_o = (gcnt_q < GCNT_W'(BUF_WORDS));
  assign push   = wr_valid_i && wr_ready_o && (cnt[wr_ch_i] < CNT_W'(SLOT_WORDS));
  assign drop   = wr_valid_i && !push;
  assign pop    = (st_q == ST_BURST) && rd_ready_i;
  assign accept = req_valid_o && req_ready_i;

  rxb_store #(.N_CH(N_CH), .SLOT(SLOT_WORDS), .DW(DW)) u_store (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .push_i      (push),
    .push_ch_i   (wr_ch_i),
    .push_data_i (wr_data_i),
    .push_eof_i  (wr_eof_i),
    .pop_i       (pop),
    .pop_ch_i    (bch_q),
    .head_data_o (rd_data_o),
    .head_eof_o  (rd_eof_o),
    .q_ch_i      (gnt_ch),
    .q_eof_off_o (eof_off),
    .cnt_o       (cnt),
    .eof_any_o   (eof_any)
  );

  always_comb begin
    for (int c = 0; c < N_CH; c++)
      req_vec[c] = (st_q == ST_IDLE) &&
                   ((cnt[c] >= CNT_W'(thr_words(thr_q[c]))) || eof_any[c]);
  end

  rxb_rr_arb #(.N(N_CH)) u_arb (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .req_i       (req_vec),
    .adv_i       (accept),
    .gnt_valid_o (gnt_valid),
    .gnt_ch_o    (gnt_ch)
  );

  // burst length = min(pending, threshold, words through first frame end)
  always_comb begin
    thr_g = CNT_W'(thr_words(thr_q[gnt_ch]));
    len_c = cnt[gnt_ch];
    if (thr_g < len_c) len_c = thr_g;
    if (eof_off + 1'b1 < len_c) len_c = eof_off + 1'b1;
  end

  assign req_valid_o = (st_q == ST_IDLE) && gnt_valid;
  assign req_ch_o    = gnt_ch;
  assign req_len_o   = len_c;
  assign rd_valid_o  = (st_q == ST_BURST);
  assign rd_last_o   = (st_q == ST_BURST) && (left_q == CNT_W'(1));
  assign ovf_o       = ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int c = 0; c < N_CH; c++) thr_q[c] <= 2'd0;
      gcnt_q <= '0;
      ovf_q  <= '0;
      st_q   <= ST_IDLE;
      bch_q  <= '0;
      left_q <= '0;
    end else begin
      if (cfg_we_i) thr_q[cfg_ch_i] <= cfg_thr_i;
      gcnt_q <= gcnt_q + {{(GCNT_W-1){1'b0}}, push} - {{(GCNT_W-1){1'b0}}, pop};
      if (drop) ovf_q[wr_ch_i] <= 1'b1;
      case (st_q)
        ST_IDLE: if (accept) begin
          st_q   <= ST_BURST;
          bch_q  <= gnt_ch;
          left_q <= len_c;
        end
        ST_BURST: if (rd_ready_i) begin
          left_q <= left_q - 1'b1;
          if (left_q == CNT_W'(1)) st_q <= ST_IDLE;
        end
        default: st_q <= ST_IDLE;
      endcase
    end
  end

  AST_GCNT_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    gcnt_q <= GCNT_W'(BUF_WORDS)); // R8
  AST_FULL_DROP: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (wr_valid_i && !wr_ready_o) |=> ovf_o[$past(wr_ch_i)]); // R8
  AST_LEN_BOUND: assert property (@(posedge clk_i) disable iff (!rst_ni)
    req_valid_o |-> (req_len_o != '0 && req_len_o <= CNT_W'(thr_words(thr_q[req_ch_o])))); // R4
  AST_ONE_BURST: assert property (@(posedge clk_i) disable iff (!rst_ni)
    rd_valid_o |-> !req_valid_o); // R7
  AST_ACCEPT_STARTS: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (req_valid_o && req_ready_i) |=> rd_valid_o); // R7
  AST_EOF_CLOSES: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_valid_o && rd_eof_o) |-> rd_last_o); // R3
  AST_OVF_STICKY: assert property (@(posedge clk_i) disable iff (!rst_ni)
    1'b1 |=> ((ovf_o & $past(ovf_o)) == $past(ovf_o))); // R9
endmodule

// File: tb/rx_thresh_buf_test.sv
`timescale 1ns/1ps
module rx_thresh_buf_test;
  localparam int NC = 4;
  localparam int SW = 8;
  localparam int BW = 12;

  logic clk = 1'b0, rst_n = 1'b0;
  logic cfg_we = 0; logic [1:0] cfg_ch = 0; logic [1:0] cfg_thr = 0;
  logic wr_valid = 0; logic [1:0] wr_ch = 0; logic [31:0] wr_data = 0; logic wr_eof = 0;
  logic wr_ready, req_valid, rd_valid, rd_eof, rd_last;
  logic [1:0] req_ch; logic [3:0] req_len; logic [31:0] rd_data;
  logic req_ready = 0, rd_ready = 0;
  logic [NC-1:0] ovf;

  int n_chk = 0, n_fail = 0, cyc = 0;
  logic [32:0] mq [NC][$];

  always #2 clk = ~clk;

  rx_thresh_buf #(.N_CH(NC), .SLOT_WORDS(SW), .BUF_WORDS(BW), .DW(32)) uut (
    .clk_i(clk), .rst_ni(rst_n),
    .cfg_we_i(cfg_we), .cfg_ch_i(cfg_ch), .cfg_thr_i(cfg_thr),
    .wr_valid_i(wr_valid), .wr_ch_i(wr_ch), .wr_data_i(wr_data), .wr_eof_i(wr_eof),
    .wr_ready_o(wr_ready),
    .req_valid_o(req_valid), .req_ch_o(req_ch), .req_len_o(req_len), .req_ready_i(req_ready),
    .rd_valid_o(rd_valid), .rd_data_o(rd_data), .rd_eof_o(rd_eof), .rd_last_o(rd_last),
    .rd_ready_i(rd_ready), .ovf_o(ovf));

  task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic cfg(input int ch, input int code);
    @(negedge clk); cfg_we = 1; cfg_ch = 2'(ch); cfg_thr = 2'(code);
    @(negedge clk); cfg_we = 0;
  endtask

  task automatic wr(input int ch, input logic [31:0] d, input bit eof, input bit keep);
    @(negedge clk); wr_valid = 1; wr_ch = 2'(ch); wr_data = d; wr_eof = eof;
    @(negedge clk); wr_valid = 0; wr_eof = 0;
    if (keep) mq[ch].push_back({eof, d});
  endtask

  task automatic serve(input int ch, input int len, input string tag);
    chk(req_valid == 1'b1, tag, req_valid, 1);
    chk(req_ch == 2'(ch), tag, req_ch, ch);
    chk(req_len == 4'(len), tag, req_len, len);
    req_ready = 1;
    @(negedge clk); req_ready = 0;
    for (int w = 0; w < len; w++) begin
      logic [32:0] e;
      e = (mq[ch].size() != 0) ? mq[ch].pop_front() : 33'h0;
      chk(rd_valid == 1'b1, "R7", rd_valid, 1);
      chk(rd_data == e[31:0], "R5", rd_data, e[31:0]);
      chk(rd_eof == e[32], "R5", rd_eof, e[32]);
      chk(rd_last == (w == len - 1), "R5", rd_last, (w == len - 1));
      rd_ready = 1;
      @(negedge clk);
    end
    rd_ready = 0;
    chk(rd_valid == 1'b0, "R7", rd_valid, 0);
  endtask

  typedef struct packed {
    logic [1:0] ch; logic [1:0] code; logic [3:0] n; logic eof; logic [3:0] len;
  } vec_t;
  localparam int NV = 8;
  localparam vec_t VEC [NV] = '{
    '{2'd1, 2'd0, 4'd1, 1'b0, 4'd1},
    '{2'd1, 2'd1, 4'd2, 1'b0, 4'd2},
    '{2'd2, 2'd2, 4'd4, 1'b0, 4'd4},
    '{2'd3, 2'd3, 4'd8, 1'b0, 4'd8},
    '{2'd0, 2'd3, 4'd3, 1'b1, 4'd3},
    '{2'd2, 2'd2, 4'd2, 1'b1, 4'd2},
    '{2'd3, 2'd0, 4'd1, 1'b1, 4'd1},
    '{2'd0, 2'd1, 4'd2, 1'b1, 4'd2}
  };

  always @(posedge clk) begin
    cyc++;
    if (cyc > 50000) begin
      n_fail++; n_chk++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    // R1 reset state
    chk(wr_ready == 1'b1, "R1", wr_ready, 1);
    chk(req_valid == 1'b0, "R1", req_valid, 0);
    chk(rd_valid == 1'b0, "R1", rd_valid, 0);
    chk(ovf == '0, "R1", ovf, 0);
    wr(2, 32'hC0DE_0001, 0, 1);
    serve(2, 1, "R1");

    // table: threshold codes and frame ends (R2, R3)
    for (int v = 0; v < NV; v++) begin
      cfg(VEC[v].ch, VEC[v].code);
      for (int w = 0; w < VEC[v].n; w++) begin
        wr(VEC[v].ch, {8'(v), 8'(VEC[v].ch), 8'(w), 8'h5A},
           VEC[v].eof && (w == VEC[v].n - 1), 1);
        if (w == VEC[v].n - 2 && !VEC[v].eof)
          chk(req_valid == 1'b0, "R2", req_valid, 0);
      end
      serve(VEC[v].ch, VEC[v].len, VEC[v].eof ? "R3" : "R2");
      chk(req_valid == 1'b0, "R2", req_valid, 0);
    end

    // R6 round robin; last served channel is 0
    for (int c = 0; c < NC; c++) cfg(c, 0);
    wr(1, 32'h1111_0001, 0, 1);
    wr(3, 32'h3333_0001, 0, 1);
    wr(0, 32'h0000_0001, 0, 1);
    serve(1, 1, "R6");
    wr(1, 32'h1111_0002, 0, 1);
    serve(3, 1, "R6");
    serve(0, 1, "R6");
    serve(1, 1, "R6");

    // R8 / R9 overflow paths
    cfg(0, 3); cfg(1, 3);
    for (int w = 0; w < 8; w++) wr(0, 32'hA000_0000 + w, 0, 1);
    chk(wr_ready == 1'b1, "R8", wr_ready, 1);
    wr(0, 32'hDEAD_0000, 0, 0);
    chk(ovf == 4'b0001, "R9", ovf, 4'b0001);
    for (int w = 0; w < 4; w++) wr(1, 32'hB000_0000 + w, 0, 1);
    chk(wr_ready == 1'b0, "R8", wr_ready, 0);
    wr(2, 32'hDEAD_0002, 0, 0);
    chk(ovf == 4'b0101, "R8", ovf, 4'b0101);
    serve(0, 8, "R9");
    chk(req_valid == 1'b0, "R2", req_valid, 0);
    chk(wr_ready == 1'b1, "R8", wr_ready, 1);
    chk(ovf == 4'b0101, "R9", ovf, 4'b0101);
    wr(1, 32'hB000_00EF, 1, 1);
    serve(1, 5, "R3");

    // R4 frame end in mid queue, and pending above threshold
    cfg(2, 3);
    wr(2, 32'hE000_0000, 0, 1);
    wr(2, 32'hE000_0001, 1, 1);
    wr(2, 32'hE000_0002, 0, 1);
    wr(2, 32'hE000_0003, 0, 1);
    serve(2, 2, "R4");
    chk(req_valid == 1'b0, "R4", req_valid, 0);
    wr(2, 32'hE000_0004, 1, 1);
    serve(2, 3, "R4");
    cfg(3, 1);
    for (int w = 0; w < 3; w++) wr(3, 32'hF000_0000 + w, 0, 1);
    serve(3, 2, "R4");
    chk(req_valid == 1'b0, "R4", req_valid, 0);
    wr(3, 32'hF000_0003, 0, 1);
    serve(3, 2, "R4");

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule